// File: doc/BRIEF.md
# Interrupt Controller Operation-Command Unit

This block is the runtime command path of an eight-input priority interrupt controller. A processor writes command bytes over a small bus made of a chip select, a write strobe, one address bit and an 8-bit data bus. The block decodes three kinds of command byte. A mask write loads the mask register. An end-of-interrupt and priority command clears in-service bits and moves the lowest-priority level. A mode and read-select command turns special mask mode on or off and picks the register shown on the read path.

The block keeps the in-service register and the rotating priority pointer. It resolves the highest-priority request that is pending and unmasked and is allowed to interrupt. An acknowledge pulse moves the presented request into service. Initialization, cascading and vector output belong to neighbouring logic.

Top module: `ocw_unit`

## Requirements
- R1: A write with `cs_i=1`, `wr_i=1`, `a0_i=1` loads all eight data bits into the mask register on the next clock edge, with bit n governing request n. While `a0_i=1`, `rd_data_o` shows the mask register.
- R2: A request whose mask bit is 1 is never presented on `int_o`/`int_id_o`. A request whose mask bit is 0 may be presented.
- R3: A write with `a0_i=0` is decoded as an end-of-interrupt/priority command when D4=0 and D3=0. It is decoded as a mode/read-select command when D4=0 and D3=1. It changes no state when D4=1.
- R4: The command code D7..D5=001 (non-specific end-of-interrupt) clears the in-service bit of highest priority. When no in-service bit is set, it does nothing.
- R5: The command code D7..D5=011 (specific end-of-interrupt) clears the in-service bit at the level given in D2..D0.
- R6: The command code D7..D5=101 clears the in-service bit of highest priority and makes that level the lowest priority. When no in-service bit is set, it does nothing.
- R7: The command code D7..D5=111 clears the in-service bit at level D2..D0 and makes that level the lowest priority.
- R8: The command code D7..D5=110 makes level D2..D0 the lowest priority and leaves the in-service register unchanged. The codes 000, 010 and 100 change no state.
- R9: In a mode command, D6=1 with D5=1 enters special mask mode, and D6=1 with D5=0 returns to normal mask mode. When D6=0, the mode is left unchanged whatever D5 holds.
- R10: In normal mask mode, the highest-priority unmasked pending request is presented only if its priority is above every level that is in service.
- R11: In special mask mode, the presented request is the highest-priority one among the requests that are unmasked and not in service.
- R12: A one-cycle `inta_i` while `int_o=1` sets the in-service bit of the level on `int_id_o`.
- R13: In a mode command, D1=1 selects the read-back of the `a0_i=0` read path: the in-service register when D0=1, or the raw requests when D0=0. D1=0 keeps the current selection.
- R14: After reset, the mask and in-service registers are 0, special mask mode is off, the read path shows the raw requests, and level 0 has the highest priority with level 7 the lowest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| a0_i | input | 1 | Address bit; selects the command word and the read path |
| data_i | input | 8 | Write data |
| irq_i | input | 8 | Pending request lines, level sensitive |
| inta_i | input | 1 | Acknowledge pulse; moves the presented request into service |
| int_o | output | 1 | A request is being presented |
| int_id_o | output | 3 | Level of the presented request |
| rd_data_o | output | 8 | Read-back: mask when `a0_i=1`, otherwise the selected register |

## Verification
The bench targets rotation wrap-around. After a rotation, level 7 can outrank level 0; a resolver that scans from a fixed bit 0 would present the wrong level and would clear the wrong bit on a non-specific end-of-interrupt. It also targets the case where a pending request has exactly the in-service priority. In normal mode that request must be held back, so a comparison written as "not lower" instead of "strictly higher" would present it twice. Other corner cases are a mode command with D6=0 and D5=1, which a careless decoder would let change the mode; writes with D4 set, which must not touch any register; and the no-op command codes. The bench also covers special mask mode with lower-priority requests pending behind an in-service level. A design that ignores this mode would keep those requests blocked.

// File: rtl/ocw_pkg.sv
package ocw_pkg;
  localparam int NIRQ  = 8;
  localparam int LVL_W = $clog2(NIRQ);

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [NIRQ-1:0]  vec_t;

  localparam logic [2:0] OP_EOI_NS = 3'b001;
  localparam logic [2:0] OP_EOI_SP = 3'b011;
  localparam logic [2:0] OP_ROT_NS = 3'b101;
  localparam logic [2:0] OP_ROT_SP = 3'b111;
  localparam logic [2:0] OP_SETPRI = 3'b110;

  typedef struct packed {
    logic       mask_we;
    logic       ctl_we;
    logic       mode_we;
    logic [2:0] op;
    lvl_t       lvl;
    logic       smm_en;
    logic       smm_val;
    logic       rsel_en;
    logic       rsel_isr;
  } cmd_t;

  // 0 is the highest rank; the level just above the lowest one ranks 0
  function automatic lvl_t prio_rank(lvl_t lvl, lvl_t lowest);
    return lvl - lowest - lvl_t'(1);
  endfunction
endpackage

// File: rtl/ocw_decode.sv
module ocw_decode
  import ocw_pkg::*;
(
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic       a0_i,
  input  logic [7:0] data_i,
  output cmd_t       cmd_o
);
  logic wr_en;
  assign wr_en = cs_i & wr_i;

  always_comb begin
    cmd_o          = '0;
    cmd_o.mask_we  = wr_en & a0_i;
    cmd_o.ctl_we   = wr_en & ~a0_i & (data_i[4:3] == 2'b00);
    cmd_o.mode_we  = wr_en & ~a0_i & (data_i[4:3] == 2'b01);
    cmd_o.op       = data_i[7:5];
    cmd_o.lvl      = data_i[LVL_W-1:0];
    cmd_o.smm_en   = data_i[6];
    cmd_o.smm_val  = data_i[5];
    cmd_o.rsel_en  = data_i[1];
    cmd_o.rsel_isr = data_i[0];
  end
endmodule

// File: rtl/ocw_prio_pick.sv
module ocw_prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] lowest_i,
  output logic          hit_o,
  output logic [LW-1:0] idx_o
);
  logic [LW-1:0] cand;

  // scan from the level just after the lowest one, wrapping around
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    cand  = '0;
    for (int k = 0; k < N; k++) begin
      cand = lowest_i + LW'(k + 1);
      if (!hit_o && vec_i[cand]) begin
        hit_o = 1'b1;
        idx_o = cand;
      end
    end
  end
endmodule

// File: rtl/ocw_unit.sv
module ocw_unit
  import ocw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       wr_i,
  input  logic       a0_i,
  input  logic [7:0] data_i,
  input  logic [7:0] irq_i,
  input  logic       inta_i,
  output logic       int_o,
  output logic [2:0] int_id_o,
  output logic [7:0] rd_data_o
);
  cmd_t cmd;
  vec_t imr_q, isr_q, isr_d;
  lvl_t lp_q, lp_d;
  logic smm_q, rsel_isr_q;

  logic hit_is, hit_rq, hit_sp;
  lvl_t top_is, top_rq, top_sp;
  vec_t req_open, req_spc;
  logic normal_ok;

  ocw_decode u_dec (
    .cs_i  (cs_i),
    .wr_i  (wr_i),
    .a0_i  (a0_i),
    .data_i(data_i),
    .cmd_o (cmd)
  );

  assign req_open = irq_i & ~imr_q;
  assign req_spc  = req_open & ~isr_q;

  ocw_prio_pick #(.N(NIRQ), .LW(LVL_W)) u_pick_is (
    .vec_i(isr_q), .lowest_i(lp_q), .hit_o(hit_is), .idx_o(top_is)
  );
  ocw_prio_pick #(.N(NIRQ), .LW(LVL_W)) u_pick_rq (
    .vec_i(req_open), .lowest_i(lp_q), .hit_o(hit_rq), .idx_o(top_rq)
  );
  ocw_prio_pick #(.N(NIRQ), .LW(LVL_W)) u_pick_sp (
    .vec_i(req_spc), .lowest_i(lp_q), .hit_o(hit_sp), .idx_o(top_sp)
  );

  assign normal_ok = hit_rq &&
                     (!hit_is || (prio_rank(top_rq, lp_q) < prio_rank(top_is, lp_q)));

  assign int_o    = smm_q ? hit_sp : normal_ok;
  assign int_id_o = smm_q ? top_sp : top_rq;

  assign rd_data_o = a0_i ? imr_q : (rsel_isr_q ? isr_q : irq_i);

  always_comb begin
    isr_d = isr_q;
    lp_d  = lp_q;
    if (inta_i && int_o) isr_d[int_id_o] = 1'b1;
    if (cmd.ctl_we) begin
      case (cmd.op)
        OP_EOI_NS: if (hit_is) isr_d[top_is] = 1'b0;
        OP_EOI_SP: isr_d[cmd.lvl] = 1'b0;
        OP_ROT_NS: if (hit_is) begin
          isr_d[top_is] = 1'b0;
          lp_d          = top_is;
        end
        OP_ROT_SP: begin
          isr_d[cmd.lvl] = 1'b0;
          lp_d           = cmd.lvl;
        end
        OP_SETPRI: lp_d = cmd.lvl;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_q      <= '0;
      isr_q      <= '0;
      lp_q       <= lvl_t'(NIRQ - 1);
      smm_q      <= 1'b0;
      rsel_isr_q <= 1'b0;
    end else begin
      isr_q <= isr_d;
      lp_q  <= lp_d;
      if (cmd.mask_we) imr_q <= data_i;
      if (cmd.mode_we && cmd.smm_en) smm_q <= cmd.smm_val;
      if (cmd.mode_we && cmd.rsel_en) rsel_isr_q <= cmd.rsel_isr;
    end
  end
endmodule

// File: rtl/ocw_unit_chk.sv
module ocw_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       wr_i,
  input logic       a0_i,
  input logic [7:0] data_i,
  input logic       inta_i,
  input logic [7:0] irq_i,
  input logic       int_o,
  input logic [2:0] int_id_o,
  input logic [7:0] imr_q,
  input logic [7:0] isr_q,
  input logic       smm_q
);
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && a0_i) |=> (imr_q == $past(data_i))); // R1

  AST_MASK_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (!imr_q[int_id_o] && irq_i[int_id_o])); // R2

  AST_D4_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !a0_i && data_i[4] && !inta_i) |=>
      (imr_q == $past(imr_q) && isr_q == $past(isr_q) && smm_q == $past(smm_q))); // R3

  AST_SPEC_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !a0_i && data_i[7:3] == 5'b01100 && !inta_i) |=>
      !isr_q[$past(data_i[2:0])]); // R5

  AST_SMM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !a0_i && data_i[4:3] == 2'b01 && !data_i[6]) |=>
      (smm_q == $past(smm_q))); // R9

  AST_NORMAL_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smm_q && int_o) |-> !isr_q[int_id_o]); // R10

  AST_SPECIAL_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smm_q && int_o) |-> !isr_q[int_id_o]); // R11

  AST_ACK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o && !(cs_i && wr_i)) |=> isr_q[$past(int_id_o)]); // R12
endmodule

bind ocw_unit ocw_unit_chk u_chk (.*);

// File: tb/ocw_unit_tb.sv
`timescale 1ns/100ps
module ocw_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, a0 = 1'b0, inta = 1'b0;
  logic [7:0] data = '0, irq = '0;
  logic       int_w;
  logic [2:0] id_w;
  logic [7:0] rd_w;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_imr = '0, m_isr = '0;
  logic [2:0] m_lp = 3'd7;
  logic       m_smm = 1'b0, m_ris = 1'b0;

  always #2.5 clk = ~clk;

  ocw_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .wr_i(wr), .a0_i(a0),
    .data_i(data), .irq_i(irq), .inta_i(inta),
    .int_o(int_w), .int_id_o(id_w), .rd_data_o(rd_w)
  );

  function automatic logic [2:0] m_rank(logic [2:0] n, logic [2:0] lp);
    return n - lp - 3'd1;
  endfunction

  // {hit, idx} of the highest-priority set bit
  function automatic logic [3:0] m_top(logic [7:0] v, logic [2:0] lp);
    for (int k = 1; k <= 8; k++) begin
      logic [2:0] i;
      i = lp + 3'(k);
      if (v[i]) return {1'b1, i};
    end
    return 4'b0;
  endfunction

  function automatic logic [3:0] m_present();
    logic [3:0] r, s;
    if (m_smm) return m_top(irq & ~m_imr & ~m_isr, m_lp);
    r = m_top(irq & ~m_imr, m_lp);
    s = m_top(m_isr, m_lp);
    if (r[3] && (!s[3] || m_rank(r[2:0], m_lp) < m_rank(s[2:0], m_lp))) return r;
    return 4'b0;
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [3:0] p;
    p = m_present();
    a0 = 1'b1; #0.2;
    chk(rd_w, m_imr, {tag, " mask readback R1"});
    a0 = 1'b0; #0.2;
    chk(rd_w, m_ris ? m_isr : irq, {tag, " read select R13"});
    chk({7'd0, int_w}, {7'd0, p[3]}, {tag, " int R10"});
    if (p[3]) chk({5'd0, id_w}, {5'd0, p[2:0]}, {tag, " id R11"});
  endtask

  task automatic m_apply(logic ad, logic [7:0] d);
    logic [3:0] h;
    h = m_top(m_isr, m_lp);
    if (ad) m_imr = d;
    else if (!d[4] && !d[3]) begin
      case (d[7:5])
        3'b001: if (h[3]) m_isr[h[2:0]] = 1'b0;
        3'b011: m_isr[d[2:0]] = 1'b0;
        3'b101: if (h[3]) begin m_isr[h[2:0]] = 1'b0; m_lp = h[2:0]; end
        3'b111: begin m_isr[d[2:0]] = 1'b0; m_lp = d[2:0]; end
        3'b110: m_lp = d[2:0];
        default: ;
      endcase
    end else if (!d[4] && d[3]) begin
      if (d[6]) m_smm = d[5];
      if (d[1]) m_ris = d[0];
    end
  endtask

  task automatic do_write(logic ad, logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; a0 = ad; data = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; a0 = 1'b0;
    m_apply(ad, d);
  endtask

  task automatic do_ack();
    logic [3:0] p;
    @(negedge clk);
    p = m_present();
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    if (p[3]) m_isr[p[2:0]] = 1'b1;
  endtask

  task automatic set_irq(logic [7:0] v);
    @(negedge clk);
    irq = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned rnd;
    rnd = $urandom(32'd20250511);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk({7'd0, int_w}, 8'd0, "R14 int after reset");
    check_all("R14");

    // R10 nesting, R12 acknowledge
    set_irq(8'h0C); check_all("R10 two pending");
    do_ack(); check_all("R12 ack level 2");
    do_write(1'b0, 8'h0B); check_all("R13 select isr");
    chk(rd_w, 8'h04, "R12 isr after ack");
    set_irq(8'h08); check_all("R10 lower blocked");
    set_irq(8'h04); check_all("R10 equal level blocked");
    set_irq(8'h0D); check_all("R10 higher presented");
    do_ack(); check_all("R12 ack level 0");
    do_write(1'b0, 8'h08); check_all("R13 select kept");

    // R4 / R5
    do_write(1'b0, 8'h20); check_all("R4 nonspecific eoi");
    chk(rd_w, 8'h04, "R4 highest cleared");
    do_write(1'b0, 8'h62); check_all("R5 specific eoi");
    chk(rd_w, 8'h00, "R5 isr empty");
    do_write(1'b0, 8'h20); check_all("R4 eoi on empty isr");

    // R1 / R2
    do_write(1'b1, 8'h7F); set_irq(8'hFF); check_all("R2 only level 7 open");
    do_write(1'b1, 8'hA5); check_all("R2 mixed mask");
    do_write(1'b1, 8'hFF); check_all("R2 all masked");
    do_write(1'b1, 8'h00); check_all("R1 mask cleared");

    // R3 writes with D4 set
    do_ack();
    do_write(1'b0, 8'h3F); check_all("R3 d4 set ignored");
    do_write(1'b0, 8'hF0); check_all("R3 d4 set ignored 2");

    // R9 / R11
    set_irq(8'h81); check_all("R10 before smm");
    do_write(1'b0, 8'h28); check_all("R9 esmm off ignored");
    do_write(1'b0, 8'h68); check_all("R11 special mask on");
    do_write(1'b0, 8'h48); check_all("R9 special mask off");
    do_write(1'b0, 8'h60); check_all("R5 clear level 0");

    // R6 / R7 / R8
    set_irq(8'h00); do_write(1'b0, 8'hC2); set_irq(8'hFF);
    check_all("R8 set priority lowest 2");
    do_ack(); do_ack(); check_all("R12 nested acks");
    do_write(1'b0, 8'hA0); check_all("R6 rotate nonspecific");
    do_write(1'b0, 8'hE5); check_all("R7 rotate specific");
    do_write(1'b0, 8'h00); check_all("R8 noop 000");
    do_write(1'b0, 8'h43); check_all("R8 noop 010");
    do_write(1'b0, 8'h86); check_all("R8 noop 100");
    do_write(1'b0, 8'hC7); check_all("R8 back to default order");
    do_write(1'b0, 8'h0B); check_all("R13 final isr view");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: set_irq(8'($urandom));
        1, 6: do_ack();
        2: do_write(1'b1, 8'($urandom) & 8'($urandom) & 8'($urandom));
        3: do_write(1'b0, {3'($urandom), 2'b00, 3'($urandom)});
        4: do_write(1'b0, {1'b0, 2'($urandom), 2'b01, 1'b0, 2'($urandom)});
        default: do_write(1'b0, {3'($urandom), 1'b1, 4'($urandom)});
      endcase
      check_all("R10 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule